// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation cache. Every entry holds one virtual page-pair tag (the virtual page number with its lowest page bit dropped), an address-space identifier, a global flag, a page-size mask and two output halves. The even virtual page of the pair translates through the first half and the odd page through the second. Each half carries its own physical frame number, cacheability attribute bits, a valid flag and a write-enable (dirty) flag. Each entry has its own page size, from 4 KB upward in steps of a factor of four.

The translation port is purely combinational. A virtual address, the current address-space identifier and a store flag go in. In the same cycle exactly one of four outcomes comes out: a usable translation, a refill miss, an invalid-page fault or a write-protection fault. A usable translation comes with its physical address and attribute bits.

Maintenance software uses three operations. An indexed write loads a whole entry. An indexed read returns a whole entry one cycle after the request. A probe searches by content and, one cycle later, returns the index of the matching entry or a not-found flag. A write that would leave two entries claiming the same address is refused, and an error flag is raised. This keeps every lookup to a single match. The entry count is a parameter, and elaboration accepts only 16, 32, 48 or 64.

Top module: `tlb_paired`

## Requirements
- R1: When no entry matches, `lk_miss` is 1, the other three outcome flags are 0, and `lk_pa` and `lk_attr` are 0. A reset-only table and an address outside every written region both give this result.
- R2: An entry matches only when its page-pair tag equals `lk_va[31:13]` in the unmasked bits and its identifier equals `lk_asid`. The same address under a different identifier misses.
- R3: When an entry's global flag is 1, the identifier comparison is skipped for lookups, probes and conflict checks.
- R4: The half is chosen by bit 12+k of the virtual address, where k is the number of ones in the entry's mask. A 0 picks half 0 (`lo0`) and a 1 picks half 1 (`lo1`).
- R5: On a usable translation, `lk_pa` is `{pfn,12'b0}` with its low 12+k bits replaced by the low 12+k bits of `lk_va`. `lk_attr` is the half's attribute field. A half is packed as {pfn[19:0], attr[2:0], d, v}, with v in bit 0 and d in bit 1.
- R6: Mask bits are set in pairs from bit 0 upward (0x00 is 4 KB, 0x03 is 16 KB, 0x0F is 64 KB). Each set bit removes the corresponding low bit of the page-pair tag from the comparison, and every entry keeps its own mask.
- R7: When a matching half has v=0, `lk_inval` is 1 and `lk_hit` is 0, for loads and stores alike.
- R8: When a store (`lk_store`=1) matches a half with v=1 and d=0, `lk_mod` is 1 and `lk_hit` is 0. A store to a half with d=1 gives `lk_hit`.
- R9: `rd_en` with `rd_idx` returns, on the next cycle, `rd_vld`=1 together with the entry's {vpn2,asid} on `rd_hi`, plus `rd_g`, `rd_mask`, `rd_lo0` and `rd_lo1`.
- R10: `pr_en` with `pr_hi` = {vpn2,asid} returns, on the next cycle, `pr_vld`=1 and the matching index on `pr_idx` with `pr_nf`=0. When nothing matches, it returns `pr_nf`=1 and `pr_idx`=0.
- R11: A write whose new entry would overlap another present entry at a different index is dropped, and `wr_mm` pulses on the next cycle. Overlap means the tags agree outside the union of both masks, and either the identifiers are equal or one of the two entries is global. Rewriting the same index is never a conflict.
- R12: After reset, no entry is present and every entry reads back as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_store | input | 1 | Access is a store |
| lk_hit | output | 1 | Usable translation |
| lk_miss | output | 1 | No matching entry (refill) |
| lk_inval | output | 1 | Matching half not valid |
| lk_mod | output | 1 | Store to a write-protected half |
| lk_pa | output | 32 | Physical address (0 unless hit) |
| lk_attr | output | 3 | Cacheability attributes (0 unless hit) |
| wr_en | input | 1 | Indexed entry write |
| wr_idx | input | 4 | Write index |
| wr_hi | input | 27 | {vpn2, asid} of new entry |
| wr_g | input | 1 | Global flag of new entry |
| wr_mask | input | 8 | Page-size mask of new entry |
| wr_lo0 | input | 25 | Even half {pfn,attr,d,v} |
| wr_lo1 | input | 25 | Odd half {pfn,attr,d,v} |
| wr_mm | output | 1 | Write refused: multiple match |
| rd_en | input | 1 | Indexed entry read |
| rd_idx | input | 4 | Read index |
| rd_vld | output | 1 | Read data valid |
| rd_hi | output | 27 | Read {vpn2, asid} |
| rd_g | output | 1 | Read global flag |
| rd_mask | output | 8 | Read mask |
| rd_lo0 | output | 25 | Read even half |
| rd_lo1 | output | 25 | Read odd half |
| pr_en | input | 1 | Probe request |
| pr_hi | input | 27 | Probe {vpn2, asid} |
| pr_vld | output | 1 | Probe result valid |
| pr_idx | output | 4 | Matching index |
| pr_nf | output | 1 | Probe found nothing |

## Verification
On every cycle the assertions check four things. The translation port raises exactly one outcome flag. A miss carries a zero address and zero attributes. At most one entry ever matches a lookup. Reads, probes and refused writes answer exactly one cycle after their request, and a not-found probe reports index zero. Only the bench's scenarios can show that the right half is chosen, that addresses are merged correctly for several page sizes, and how the global flag and the identifier affect matching. The same holds for which overlaps are refused and which rewrites are allowed, and for whether an entry reads back with the contents it was given.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // Outcome of a translation
   typedef enum logic [1:0] {
      LK_MISS  = 2'd0,
      LK_INVAL = 2'd1,
      LK_MOD   = 2'd2,
      LK_HIT   = 2'd3
   } lk_res_e;

   // Packing of one output half: {pfn, attr, d, v}
   localparam int LO_V_BIT    = 0;
   localparam int LO_D_BIT    = 1;
   localparam int LO_ATTR_LSB = 2;
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
   parameter int VPN2_W = 19,
   parameter int ASID_W = 8,
   parameter int MASK_W = 8,
   parameter int LO_W   = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [VPN2_W-1:0] wr_vpn2,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_g,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [LO_W-1:0]   wr_lo0,
   input  logic [LO_W-1:0]   wr_lo1,
   input  logic [VPN2_W-1:0] lk_vpn2,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_match,
   input  logic [VPN2_W-1:0] pr_vpn2,
   input  logic [ASID_W-1:0] pr_asid,
   output logic              pr_match,
   output logic              conflict,
   output logic [VPN2_W-1:0] q_vpn2,
   output logic [ASID_W-1:0] q_asid,
   output logic              q_g,
   output logic [MASK_W-1:0] q_mask,
   output logic [LO_W-1:0]   q_lo0,
   output logic [LO_W-1:0]   q_lo1
);
   localparam int PAD_W = VPN2_W - MASK_W;

   logic              present;
   logic [VPN2_W-1:0] own_ign;
   logic [VPN2_W-1:0] new_ign;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         present <= 1'b0;
         q_vpn2  <= '0;
         q_asid  <= '0;
         q_g     <= 1'b0;
         q_mask  <= '0;
         q_lo0   <= '0;
         q_lo1   <= '0;
      end else if (we) begin
         present <= 1'b1;
         q_vpn2  <= wr_vpn2;
         q_asid  <= wr_asid;
         q_g     <= wr_g;
         q_mask  <= wr_mask;
         q_lo0   <= wr_lo0;
         q_lo1   <= wr_lo1;
      end
   end

   assign own_ign = {{PAD_W{1'b0}}, q_mask};
   assign new_ign = {{PAD_W{1'b0}}, wr_mask};

   // Translation compare
   assign lk_match = present
                   && (((lk_vpn2 ^ q_vpn2) & ~own_ign) == '0)
                   && (q_g || (lk_asid == q_asid));

   // Probe compare
   assign pr_match = present
                   && (((pr_vpn2 ^ q_vpn2) & ~own_ign) == '0)
                   && (q_g || (pr_asid == q_asid));

   // Overlap with an incoming entry (union of both masks)
   assign conflict = present
                   && (((wr_vpn2 ^ q_vpn2) & ~(own_ign | new_ign)) == '0)
                   && (q_g || wr_g || (wr_asid == q_asid));
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tlb_paired.sv
module tlb_paired
   import tlb_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int VA_W      = 32,
   parameter int PG_SHIFT  = 12,
   parameter int ASID_W    = 8,
   parameter int MASK_W    = 8,
   parameter int PFN_W     = 20,
   parameter int ATTR_W    = 3,
   localparam int VPN2_W   = VA_W - PG_SHIFT - 1,
   localparam int HI_W     = VPN2_W + ASID_W,
   localparam int LO_W     = PFN_W + ATTR_W + 2,
   localparam int IDX_W    = $clog2(N_ENTRIES),
   localparam int PA_W     = PFN_W + PG_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_store,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic              lk_inval,
   output logic              lk_mod,
   output logic [PA_W-1:0]   lk_pa,
   output logic [ATTR_W-1:0] lk_attr,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [HI_W-1:0]   wr_hi,
   input  logic              wr_g,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [LO_W-1:0]   wr_lo0,
   input  logic [LO_W-1:0]   wr_lo1,
   output logic              wr_mm,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_vld,
   output logic [HI_W-1:0]   rd_hi,
   output logic              rd_g,
   output logic [MASK_W-1:0] rd_mask,
   output logic [LO_W-1:0]   rd_lo0,
   output logic [LO_W-1:0]   rd_lo1,
   input  logic              pr_en,
   input  logic [HI_W-1:0]   pr_hi,
   output logic              pr_vld,
   output logic [IDX_W-1:0]  pr_idx,
   output logic              pr_nf
);
   localparam int POS_W = $clog2(VA_W);
   localparam int CNT_W = $clog2(MASK_W + 1);

   // Elaboration-time parameter checks
   if (!(N_ENTRIES == 16 || N_ENTRIES == 32 || N_ENTRIES == 48 || N_ENTRIES == 64)) begin : g_bad_n
      $error("tlb_paired: N_ENTRIES must be 16, 32, 48 or 64");
   end
   if ((MASK_W % 2) != 0) begin : g_bad_mask
      $error("tlb_paired: MASK_W must be even");
   end
   if (MASK_W >= VPN2_W) begin : g_bad_span
      $error("tlb_paired: MASK_W must be narrower than the page-pair tag");
   end
   if (PA_W > VA_W + PFN_W) begin : g_bad_pa
      $error("tlb_paired: inconsistent address widths");
   end

   // Entry storage views
   logic [VPN2_W-1:0] e_vpn2 [N_ENTRIES];
   logic [ASID_W-1:0] e_asid [N_ENTRIES];
   logic              e_g    [N_ENTRIES];
   logic [MASK_W-1:0] e_mask [N_ENTRIES];
   logic [LO_W-1:0]   e_lo0  [N_ENTRIES];
   logic [LO_W-1:0]   e_lo1  [N_ENTRIES];

   logic [N_ENTRIES-1:0] lk_match;
   logic [N_ENTRIES-1:0] pr_match;
   logic [N_ENTRIES-1:0] conflict;
   logic [N_ENTRIES-1:0] conflict_other;
   logic [N_ENTRIES-1:0] we;

   logic [VPN2_W-1:0] lk_vpn2;
   logic [VPN2_W-1:0] wr_vpn2;
   logic [ASID_W-1:0] wr_asid;
   logic [VPN2_W-1:0] pr_vpn2;
   logic [ASID_W-1:0] pr_asid;
   logic              wr_ok;
   logic              rd_ok;
   logic              wr_go;

   assign lk_vpn2 = lk_va[VA_W-1:PG_SHIFT+1];
   assign wr_vpn2 = wr_hi[HI_W-1:ASID_W];
   assign wr_asid = wr_hi[ASID_W-1:0];
   assign pr_vpn2 = pr_hi[HI_W-1:ASID_W];
   assign pr_asid = pr_hi[ASID_W-1:0];

   // Index range guard: needed only when the count is not a power of two
   if ((1 << IDX_W) == N_ENTRIES) begin : g_idx_full
      assign wr_ok = 1'b1;
      assign rd_ok = 1'b1;
   end else begin : g_idx_part
      assign wr_ok = (int'(wr_idx) < N_ENTRIES);
      assign rd_ok = (int'(rd_idx) < N_ENTRIES);
   end

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
      assign conflict_other[i] = conflict[i] && (wr_idx != IDX_W'(i));
      assign we[i]             = wr_go && (wr_idx == IDX_W'(i));

      tlb_entry #(
         .VPN2_W (VPN2_W),
         .ASID_W (ASID_W),
         .MASK_W (MASK_W),
         .LO_W   (LO_W)
      ) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (we[i]),
         .wr_vpn2  (wr_vpn2),
         .wr_asid  (wr_asid),
         .wr_g     (wr_g),
         .wr_mask  (wr_mask),
         .wr_lo0   (wr_lo0),
         .wr_lo1   (wr_lo1),
         .lk_vpn2  (lk_vpn2),
         .lk_asid  (lk_asid),
         .lk_match (lk_match[i]),
         .pr_vpn2  (pr_vpn2),
         .pr_asid  (pr_asid),
         .pr_match (pr_match[i]),
         .conflict (conflict[i]),
         .q_vpn2   (e_vpn2[i]),
         .q_asid   (e_asid[i]),
         .q_g      (e_g[i]),
         .q_mask   (e_mask[i]),
         .q_lo0    (e_lo0[i]),
         .q_lo1    (e_lo1[i])
      );
   end

   assign wr_go = wr_en && wr_ok && (conflict_other == '0);

   // Translation path
   logic [IDX_W-1:0]  lk_idx;
   logic              lk_any;
   logic [MASK_W-1:0] sel_mask;
   logic [CNT_W-1:0]  sel_cnt;
   logic [POS_W-1:0]  odd_pos;
   logic [LO_W-1:0]   sel_lo;
   logic [PA_W-1:0]   off_msk;
   logic [PA_W-1:0]   frame_pa;
   lk_res_e           res;

   tlb_prio_enc #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_lk_enc (
      .req (lk_match),
      .idx (lk_idx),
      .any (lk_any)
   );

   always_comb begin
      sel_mask = e_mask[lk_idx];
      sel_cnt  = CNT_W'($countones(sel_mask));
      odd_pos  = POS_W'(PG_SHIFT) + POS_W'(sel_cnt);
      sel_lo   = lk_va[odd_pos] ? e_lo1[lk_idx] : e_lo0[lk_idx];
      off_msk  = (PA_W'(1) << odd_pos) - PA_W'(1);
      frame_pa = ({sel_lo[LO_W-1:ATTR_W+LO_ATTR_LSB], {PG_SHIFT{1'b0}}} & ~off_msk)
               | (PA_W'(lk_va) & off_msk);
      if (!lk_any)                               res = LK_MISS;
      else if (!sel_lo[LO_V_BIT])                res = LK_INVAL;
      else if (lk_store && !sel_lo[LO_D_BIT])    res = LK_MOD;
      else                                       res = LK_HIT;
   end

   assign lk_hit   = (res == LK_HIT);
   assign lk_miss  = (res == LK_MISS);
   assign lk_inval = (res == LK_INVAL);
   assign lk_mod   = (res == LK_MOD);
   assign lk_pa    = lk_hit ? frame_pa : '0;
   assign lk_attr  = lk_hit ? sel_lo[ATTR_W+LO_ATTR_LSB-1:LO_ATTR_LSB] : '0;

   // Probe path
   logic [IDX_W-1:0] pr_sel;
   logic             pr_any;

   tlb_prio_enc #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_pr_enc (
      .req (pr_match),
      .idx (pr_sel),
      .any (pr_any)
   );

   // Registered maintenance results
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_mm   <= 1'b0;
         rd_vld  <= 1'b0;
         rd_hi   <= '0;
         rd_g    <= 1'b0;
         rd_mask <= '0;
         rd_lo0  <= '0;
         rd_lo1  <= '0;
         pr_vld  <= 1'b0;
         pr_idx  <= '0;
         pr_nf   <= 1'b0;
      end else begin
         wr_mm  <= wr_en && wr_ok && (conflict_other != '0);
         rd_vld <= rd_en;
         if (rd_en) begin
            if (rd_ok) begin
               rd_hi   <= {e_vpn2[rd_idx], e_asid[rd_idx]};
               rd_g    <= e_g[rd_idx];
               rd_mask <= e_mask[rd_idx];
               rd_lo0  <= e_lo0[rd_idx];
               rd_lo1  <= e_lo1[rd_idx];
            end else begin
               rd_hi   <= '0;
               rd_g    <= 1'b0;
               rd_mask <= '0;
               rd_lo0  <= '0;
               rd_lo1  <= '0;
            end
         end
         pr_vld <= pr_en;
         if (pr_en) begin
            pr_idx <= pr_any ? pr_sel : '0;
            pr_nf  <= !pr_any;
         end
      end
   end
endmodule

// File: rtl/tlb_paired_chk.sv
module tlb_paired_chk #(
   parameter int N_ENTRIES = 16,
   parameter int PA_W      = 32,
   parameter int ATTR_W    = 3,
   parameter int IDX_W     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 lk_hit,
   input logic                 lk_miss,
   input logic                 lk_inval,
   input logic                 lk_mod,
   input logic [PA_W-1:0]      lk_pa,
   input logic [ATTR_W-1:0]    lk_attr,
   input logic [N_ENTRIES-1:0] lk_match,
   input logic                 wr_en,
   input logic                 wr_mm,
   input logic                 rd_en,
   input logic                 rd_vld,
   input logic                 pr_en,
   input logic                 pr_vld,
   input logic [IDX_W-1:0]     pr_idx,
   input logic                 pr_nf
);
   // R1, R7, R8: exactly one outcome per lookup
   a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({lk_hit, lk_miss, lk_inval, lk_mod}) == 1);

   // R1: a miss carries no translation
   a_r1_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |-> (lk_pa == '0 && lk_attr == '0));

   // R11: refused overlaps keep every lookup to one matching entry
   a_r11_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

   // R11: the error pulse follows a write request
   a_r11_mm_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mm |-> $past(wr_en));

   // R9: read answers one cycle later, and only then
   a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_vld);
   a_r9_read_source: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |-> $past(rd_en));

   // R10: probe answers one cycle later; not-found reports index zero
   a_r10_probe_latency: assert property (@(posedge clk) disable iff (!rst_n)
      pr_en |=> pr_vld);
   a_r10_nf_index: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_vld && pr_nf) |-> (pr_idx == '0));
endmodule

bind tlb_paired tlb_paired_chk #(
   .N_ENTRIES (N_ENTRIES),
   .PA_W      (PA_W),
   .ATTR_W    (ATTR_W),
   .IDX_W     (IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_hit   (lk_hit),
   .lk_miss  (lk_miss),
   .lk_inval (lk_inval),
   .lk_mod   (lk_mod),
   .lk_pa    (lk_pa),
   .lk_attr  (lk_attr),
   .lk_match (lk_match),
   .wr_en    (wr_en),
   .wr_mm    (wr_mm),
   .rd_en    (rd_en),
   .rd_vld   (rd_vld),
   .pr_en    (pr_en),
   .pr_vld   (pr_vld),
   .pr_idx   (pr_idx),
   .pr_nf    (pr_nf)
);

// File: tb/tlb_paired_tb.sv
module tlb_paired_tb;
   localparam logic [3:0] OC_HIT = 4'b1000;
   localparam logic [3:0] OC_MISS = 4'b0100;
   localparam logic [3:0] OC_INV = 4'b0010;
   localparam logic [3:0] OC_MOD = 4'b0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_store = 1'b0;
   logic        lk_hit, lk_miss, lk_inval, lk_mod;
   logic [31:0] lk_pa;
   logic [2:0]  lk_attr;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [26:0] wr_hi = '0;
   logic        wr_g = 1'b0;
   logic [7:0]  wr_mask = '0;
   logic [24:0] wr_lo0 = '0;
   logic [24:0] wr_lo1 = '0;
   logic        wr_mm;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_idx = '0;
   logic        rd_vld;
   logic [26:0] rd_hi;
   logic        rd_g;
   logic [7:0]  rd_mask;
   logic [24:0] rd_lo0, rd_lo1;
   logic        pr_en = 1'b0;
   logic [26:0] pr_hi = '0;
   logic        pr_vld;
   logic [3:0]  pr_idx;
   logic        pr_nf;

   always #2 clk = ~clk;

   tlb_paired u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_va(lk_va), .lk_asid(lk_asid), .lk_store(lk_store),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_inval(lk_inval), .lk_mod(lk_mod),
      .lk_pa(lk_pa), .lk_attr(lk_attr),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_g(wr_g),
      .wr_mask(wr_mask), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1), .wr_mm(wr_mm),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_hi(rd_hi),
      .rd_g(rd_g), .rd_mask(rd_mask), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1),
      .pr_en(pr_en), .pr_hi(pr_hi), .pr_vld(pr_vld), .pr_idx(pr_idx), .pr_nf(pr_nf)
   );

   typedef struct {
      int           due;
      int           kind;   // 0 lookup, 1 read, 2 probe, 3 write error flag
      logic [127:0] exp;
      string        tag;
   } item_t;

   item_t sb_q[$];
   int    ncyc = 0;
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   function automatic logic [24:0] mklo(input logic [19:0] pfn, input logic [2:0] attr,
                                        input logic d, input logic v);
      return {pfn, attr, d, v};
   endfunction

   // Monitor: samples at the falling edge, away from the active edge
   always @(negedge clk) begin
      ncyc++;
      while (sb_q.size() != 0 && sb_q[0].due == ncyc) begin
         item_t it;
         logic [127:0] act;
         it = sb_q.pop_front();
         case (it.kind)
            0:       act = 128'({lk_hit, lk_miss, lk_inval, lk_mod, lk_attr, lk_pa});
            1:       act = 128'({rd_vld, rd_hi, rd_g, rd_mask, rd_lo0, rd_lo1});
            2:       act = 128'({pr_vld, pr_nf, pr_idx});
            default: act = 128'(wr_mm);
         endcase
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic clear_pulses();
      wr_en = 1'b0;
      rd_en = 1'b0;
      pr_en = 1'b0;
   endtask

   task automatic push(input int due, input int kind, input logic [127:0] exp, input string tag);
      item_t it;
      it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic lk(input logic [31:0] va, input logic [7:0] asid, input logic st,
                     input logic [3:0] oc, input logic [2:0] attr, input logic [31:0] pa,
                     input string tag);
      @(posedge clk); #1;
      clear_pulses();
      lk_va = va; lk_asid = asid; lk_store = st;
      push(ncyc + 1, 0, 128'({oc, attr, pa}), tag);
   endtask

   task automatic wr(input logic [3:0] idx, input logic [18:0] vpn2, input logic [7:0] asid,
                     input logic g, input logic [7:0] mask, input logic [24:0] lo0,
                     input logic [24:0] lo1, input logic exp_mm, input string tag);
      @(posedge clk); #1;
      clear_pulses();
      wr_en = 1'b1; wr_idx = idx; wr_hi = {vpn2, asid}; wr_g = g;
      wr_mask = mask; wr_lo0 = lo0; wr_lo1 = lo1;
      push(ncyc + 2, 3, 128'(exp_mm), tag);
   endtask

   task automatic rd(input logic [3:0] idx, input logic [18:0] vpn2, input logic [7:0] asid,
                     input logic g, input logic [7:0] mask, input logic [24:0] lo0,
                     input logic [24:0] lo1, input string tag);
      @(posedge clk); #1;
      clear_pulses();
      rd_en = 1'b1; rd_idx = idx;
      push(ncyc + 2, 1, 128'({1'b1, vpn2, asid, g, mask, lo0, lo1}), tag);
   endtask

   task automatic pr(input logic [18:0] vpn2, input logic [7:0] asid,
                     input logic nf, input logic [3:0] idx, input string tag);
      @(posedge clk); #1;
      clear_pulses();
      pr_en = 1'b1; pr_hi = {vpn2, asid};
      push(ncyc + 2, 2, 128'({1'b1, nf, idx}), tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R12 / R1: empty table after reset
      lk(32'h0000_0000, 8'd0, 1'b0, OC_MISS, 3'd0, 32'd0, "R12 reset lookup misses");
      rd(4'd0, 19'd0, 8'd0, 1'b0, 8'd0, 25'd0, 25'd0, "R12 reset entry reads zero");

      // Populate
      wr(4'd0, 19'h00010, 8'd5, 1'b0, 8'h00, mklo(20'h11111, 3'd3, 1'b1, 1'b1),
         mklo(20'h22222, 3'd2, 1'b0, 1'b1), 1'b0, "R11 write e0 accepted");
      wr(4'd1, 19'h00100, 8'd9, 1'b1, 8'h00, mklo(20'h00000, 3'd0, 1'b0, 1'b0),
         mklo(20'h00333, 3'd5, 1'b1, 1'b1), 1'b0, "R11 write e1 accepted");
      wr(4'd2, 19'h00800, 8'd5, 1'b0, 8'h0F, mklo(20'h40000, 3'd1, 1'b1, 1'b1),
         mklo(20'h50000, 3'd1, 1'b1, 1'b1), 1'b0, "R11 write e2 accepted");
      wr(4'd15, 19'h01800, 8'd5, 1'b0, 8'h03, mklo(20'h12340, 3'd4, 1'b1, 1'b1),
         mklo(20'h56780, 3'd6, 1'b1, 1'b1), 1'b0, "R11 write e15 accepted");

      // 4 KB entry: halves, address merge, identifier, write protection
      lk(32'h0002_0123, 8'd5, 1'b0, OC_HIT, 3'd3, 32'h1111_1123, "R4 R5 even half");
      lk(32'h0002_1456, 8'd5, 1'b0, OC_HIT, 3'd2, 32'h2222_2456, "R4 R5 odd half");
      lk(32'h0002_1456, 8'd5, 1'b1, OC_MOD, 3'd0, 32'd0, "R8 store to clean half");
      lk(32'h0002_0123, 8'd5, 1'b1, OC_HIT, 3'd3, 32'h1111_1123, "R8 store to dirty half");
      lk(32'h0002_0123, 8'd6, 1'b0, OC_MISS, 3'd0, 32'd0, "R2 identifier mismatch");

      // Global entry with an invalid even half
      lk(32'h0020_0010, 8'd1, 1'b0, OC_INV, 3'd0, 32'd0, "R7 invalid half load");
      lk(32'h0020_0010, 8'd1, 1'b1, OC_INV, 3'd0, 32'd0, "R7 invalid half store");
      lk(32'h0020_1010, 8'd77, 1'b0, OC_HIT, 3'd5, 32'h0033_3010, "R3 global ignores identifier");

      // 64 KB and 16 KB entries
      lk(32'h0100_ABCD, 8'd5, 1'b0, OC_HIT, 3'd1, 32'h4000_ABCD, "R6 R5 64K even");
      lk(32'h0101_2345, 8'd5, 1'b0, OC_HIT, 3'd1, 32'h5000_2345, "R6 R4 64K odd");
      lk(32'h0102_0000, 8'd5, 1'b0, OC_MISS, 3'd0, 32'd0, "R1 R6 beyond 64K pair");
      lk(32'h0300_6001, 8'd5, 1'b0, OC_HIT, 3'd6, 32'h5678_2001, "R6 R4 16K odd");

      // Indexed reads
      rd(4'd15, 19'h01800, 8'd5, 1'b0, 8'h03, mklo(20'h12340, 3'd4, 1'b1, 1'b1),
         mklo(20'h56780, 3'd6, 1'b1, 1'b1), "R9 read e15");
      rd(4'd7, 19'd0, 8'd0, 1'b0, 8'd0, 25'd0, 25'd0, "R12 unwritten entry zero");

      // Probes
      pr(19'h00808, 8'd5, 1'b0, 4'd2, "R10 probe inside 64K pair");
      pr(19'h12345, 8'd5, 1'b1, 4'd0, "R10 probe not found");
      pr(19'h00100, 8'd3, 1'b0, 4'd1, "R10 R3 probe global entry");

      // Overlap handling
      wr(4'd4, 19'h00010, 8'd5, 1'b0, 8'h00, mklo(20'h77777, 3'd7, 1'b1, 1'b1),
         mklo(20'h77777, 3'd7, 1'b1, 1'b1), 1'b1, "R11 duplicate refused");
      rd(4'd4, 19'd0, 8'd0, 1'b0, 8'd0, 25'd0, 25'd0, "R11 refused write left entry");
      wr(4'd5, 19'h00010, 8'd99, 1'b1, 8'h00, mklo(20'h77777, 3'd7, 1'b1, 1'b1),
         mklo(20'h77777, 3'd7, 1'b1, 1'b1), 1'b1, "R11 R3 global overlap refused");
      wr(4'd6, 19'h00805, 8'd5, 1'b0, 8'h00, mklo(20'h77777, 3'd7, 1'b1, 1'b1),
         mklo(20'h77777, 3'd7, 1'b1, 1'b1), 1'b1, "R11 R6 overlap under mask refused");
      wr(4'd0, 19'h00010, 8'd5, 1'b0, 8'h00, mklo(20'h11111, 3'd3, 1'b1, 1'b1),
         mklo(20'h22222, 3'd2, 1'b0, 1'b1), 1'b0, "R11 same index rewrite allowed");
      wr(4'd4, 19'h00010, 8'd6, 1'b0, 8'h00, mklo(20'h77777, 3'd7, 1'b1, 1'b1),
         mklo(20'h77777, 3'd7, 1'b1, 1'b1), 1'b0, "R11 R2 other identifier accepted");
      lk(32'h0002_0000, 8'd6, 1'b0, OC_HIT, 3'd7, 32'h7777_7000, "R2 second identifier hits");
      lk(32'h0002_0000, 8'd5, 1'b0, OC_HIT, 3'd3, 32'h1111_1000, "R2 first identifier kept");

      @(posedge clk); #1;
      clear_pulses();
      repeat (4) @(posedge clk);
      #1;
      if (sb_q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule